// File: doc/BRIEF.md
# Row-Confined Write Buffer with Timed Commit

This block gathers the data bytes of one write transaction into a 16-entry row buffer and later copies them into a 256 x 8 storage array during a self-timed programming window. An upstream bus decoder gives it four qualified strobes. A start-address strobe picks the target row and the starting offset. Byte strobes carry data. A commit request arrives only when the transaction closed right after a data-byte acknowledge. An abort arrives when the transaction closed anywhere else.

Each received byte lands at the current in-row offset, and only the low four address bits then advance. A long burst therefore wraps to the start of its row and overwrites bytes latched earlier. A per-slot valid mask records which offsets hold pending data. When the commit runs, only those locations change, and the last value received for a location is the one stored. The commit holds a busy flag for a programmable number of clock cycles. The pending slots are copied into the array one slot per cycle at the start of that window. While busy is high, every strobe is dropped. The array's write port is visible at the outputs, and a combinational read port exposes its contents.

Top module: `pgb_commit`

## Requirements
- R1: After reset, busy is 0, arr_we is 0, and every array location reads FFh through the read port.
- R2: A start-address strobe accepted while idle sets the row to addr_in[7:4] and the offset to addr_in[3:0], and discards every pending byte.
- R3: Each accepted byte strobe stores byte_data at the current offset and then increments only the 4-bit offset. Offset 15 is followed by offset 0 of the same row.
- R4: When wrap-around makes a location receive more than one byte in one transaction, the commit stores the value received last.
- R5: A commit request accepted while idle with at least one pending byte raises busy at the next clock edge. Busy then stays high for exactly WR_CYCLES cycles.
- R6: A commit writes only the locations that hold a pending byte. Every other location, in the same row or in any other row, keeps its value.
- R7: An abort accepted while idle discards all pending bytes, so a later commit request with no new bytes writes nothing and leaves busy low.
- R8: A commit request while idle with no pending byte leaves busy at 0 and writes nothing.
- R9: While busy is 1, start-address strobes, byte strobes, commit requests and aborts are ignored. Bytes offered during busy are never written.
- R10: When the commit window ends, the pending bytes are cleared, so a second commit request without new bytes does nothing.
- R11: arr_we is asserted only while busy is 1. During one commit it pulses once for each distinct pending offset, and each pulse carries an address in the committed row.
- R12: When idle strobes coincide, the priority is abort, then commit request, then start-address strobe, then byte strobe. The lower-priority strobes in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Start-address strobe |
| addr_in | input | ADDR_W | Start address: row in the high bits, offset in the low OFS_W bits |
| byte_stb | input | 1 | Data byte received strobe |
| byte_data | input | DATA_W | Data byte carried by byte_stb |
| commit_req | input | 1 | Begin the timed commit of the pending bytes |
| abort | input | 1 | Drop the pending bytes without writing |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array contents at rd_addr (combinational) |
| busy | output | 1 | Commit window in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench keeps the default 8-bit address and data widths and sets WR_CYCLES to 40. With that setting the whole busy window can be counted cycle by cycle, and many commits fit in a short run. Because 40 is larger than the 16 copy slots, every arr_we pulse of a commit can be seen and counted before busy falls. The small window also makes it cheap to fire strobes in the middle of a commit and show that they have no effect.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

    localparam int unsigned PGB_ADDR_W    = 8;
    localparam int unsigned PGB_OFS_W     = 4;
    localparam int unsigned PGB_DATA_W    = 8;
    localparam int unsigned PGB_WR_CYCLES = 1_000_000;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } prog_phase_e;

    function automatic int unsigned pgb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgb_latch.sv
module pgb_latch
    import pgb_pkg::*;
#(
    parameter int unsigned ADDR_W = PGB_ADDR_W,
    parameter int unsigned OFS_W  = PGB_OFS_W,
    parameter int unsigned DATA_W = PGB_DATA_W,
    localparam int unsigned SLOTS = 1 << OFS_W,
    localparam int unsigned ROW_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              done,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit_req,
    input  logic              abort,
    input  logic [OFS_W-1:0]  sel_idx,
    output logic              go,
    output logic              pend,
    output logic [ROW_W-1:0]  row_o,
    output logic              sel_valid,
    output logic [DATA_W-1:0] sel_data
);

    logic [ROW_W-1:0]              row_q;
    logic [OFS_W-1:0]              ptr_q;
    logic [SLOTS-1:0]              mask;
    logic [SLOTS*DATA_W-1:0]       data_bus;

    logic take_abort, take_load, accept_byte, clear_all;

    // strict priority among idle strobes: abort, commit, load, byte  (R12)
    assign take_abort  = !busy && abort;
    assign go          = !busy && !abort && commit_req && (mask != '0);
    assign take_load   = !busy && !abort && !commit_req && addr_load;
    assign accept_byte = !busy && !abort && !commit_req && !addr_load && byte_stb;
    assign clear_all   = take_abort || take_load || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            ptr_q <= '0;
        end else if (take_load) begin
            row_q <= addr_in[ADDR_W-1:OFS_W];
            ptr_q <= addr_in[OFS_W-1:0];
        end else if (accept_byte) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        logic              hit;

        assign hit = accept_byte && (ptr_q == OFS_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (clear_all) begin
                v_q <= 1'b0;
            end else if (hit) begin
                v_q <= 1'b1;
                d_q <= byte_data;
            end
        end

        assign mask[i]                         = v_q;
        assign data_bus[i*DATA_W +: DATA_W]    = d_q;
    end

    assign pend      = (mask != '0);
    assign row_o     = row_q;
    assign sel_valid = mask[sel_idx];
    assign sel_data  = data_bus[sel_idx*DATA_W +: DATA_W];

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(mask) && $stable(row_q) && $stable(ptr_q))); // R9
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!busy && abort) |=> (mask == '0)); // R7
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done |=> (mask == '0)); // R10
    AST_LOAD_SETS_ROW: assert property (@(posedge clk) disable iff (rst)
        take_load |=> ((mask == '0) && (row_q == $past(addr_in[ADDR_W-1:OFS_W])))); // R2
    AST_OFS_WRAP_STEP: assert property (@(posedge clk) disable iff (rst)
        accept_byte |=> (ptr_q == OFS_W'($past(ptr_q) + 1'b1))); // R3

endmodule

// File: rtl/pgb_timer.sv
module pgb_timer
    import pgb_pkg::*;
#(
    parameter int unsigned WR_CYCLES = PGB_WR_CYCLES,
    parameter int unsigned OFS_W     = PGB_OFS_W,
    localparam int unsigned SLOTS    = 1 << OFS_W,
    localparam int unsigned CNT_W    = pgb_max($clog2(WR_CYCLES + 1), OFS_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             copying,
    output logic [OFS_W-1:0] idx
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SLOT_N = CNT_W'(SLOTS);

    prog_phase_e      ph_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q  <= PH_PROG;
                        cnt_q <= '0;
                    end
                end
                PH_PROG: begin
                    if (cnt_q == LAST) begin
                        ph_q  <= PH_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (ph_q == PH_PROG);
    assign done    = busy && (cnt_q == LAST);
    assign copying = busy && (cnt_q < SLOT_N);
    assign idx     = cnt_q[OFS_W-1:0];

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R5
    AST_IDLE_NO_COPY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !copying); // R11

endmodule

// File: rtl/pgb_array.sv
module pgb_array
    import pgb_pkg::*;
#(
    parameter int unsigned ADDR_W = PGB_ADDR_W,
    parameter int unsigned DATA_W = PGB_DATA_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // erased state is all ones  (R1)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pgb_commit.sv
module pgb_commit
    import pgb_pkg::*;
#(
    parameter int unsigned ADDR_W    = PGB_ADDR_W,
    parameter int unsigned OFS_W     = PGB_OFS_W,
    parameter int unsigned DATA_W    = PGB_DATA_W,
    parameter int unsigned WR_CYCLES = PGB_WR_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit_req,
    input  logic              abort,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int unsigned ROW_W = ADDR_W - OFS_W;

    logic              go, pend, done, copying, sel_valid;
    logic [OFS_W-1:0]  idx;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] sel_data;

    pgb_latch #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .done       (done),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .byte_stb   (byte_stb),
        .byte_data  (byte_data),
        .commit_req (commit_req),
        .abort      (abort),
        .sel_idx    (idx),
        .go         (go),
        .pend       (pend),
        .row_o      (row),
        .sel_valid  (sel_valid),
        .sel_data   (sel_data)
    );

    pgb_timer #(.WR_CYCLES(WR_CYCLES), .OFS_W(OFS_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (go),
        .busy    (busy),
        .done    (done),
        .copying (copying),
        .idx     (idx)
    );

    assign arr_we    = copying && sel_valid;
    assign arr_addr  = {row, idx};
    assign arr_wdata = sel_data;

    pgb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy); // R11
    AST_EMPTY_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && commit_req && !pend) |=> !busy); // R8
    AST_ROW_STEADY_IN_COPY: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFS_W])); // R11

endmodule

// File: tb/pgb_commit_tb.sv
`timescale 1ns/1ps
module pgb_commit_tb;

    localparam int WRC = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       addr_load, byte_stb, commit_req, abort;
    logic [7:0] addr_in, byte_data, rd_addr, rd_data, arr_addr, arr_wdata;
    logic       busy, arr_we;

    int n_chk = 0;
    int n_err = 0;
    int stray_we = 0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    pgb_commit #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_data(byte_data), .commit_req(commit_req),
        .abort(abort), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // table: {start address, byte count, first data value}
    localparam logic [23:0] VEC [7] = '{
        24'h00_01_11, 24'h35_04_20, 24'h33_01_77, 24'hF0_10_40,
        24'h7C_06_90, 24'h2A_14_A0, 24'hFF_02_C5
    };

    always @(negedge clk) if (!rst && arr_we && !busy) stray_we++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic pulse_load(input logic [7:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic pulse_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    // issue commit; measure busy length, write pulses and row errors
    task automatic do_commit(input logic [3:0] row, output int blen, output int wen, output int badrow);
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
        blen = 0; wen = 0; badrow = 0;
        while (busy && blen < 1000) begin
            blen++;
            if (arr_we) begin
                wen++;
                if (arr_addr[7:4] != row) badrow++;
            end
            @(negedge clk);
        end
    endtask

    task automatic compare_all(input string req);
        int mism = 0;
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #0.1;
            if (rd_data !== model[a]) mism++;
        end
        check(mism == 0, req, mism, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_report();
    end

    initial begin
        int blen, wen, badrow;
        rst = 1'b1; addr_load = 0; byte_stb = 0; commit_req = 0; abort = 0;
        addr_in = 0; byte_data = 0; rd_addr = 0;
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(arr_we == 1'b0, "R1 arr_we after reset", arr_we, 0);
        compare_all("R1 array erased to FF");

        // table walk: R2 R3 R4 R5 R6 R11
        for (int v = 0; v < 7; v++) begin
            logic [7:0] a0 = VEC[v][23:16];
            int         n  = int'(VEC[v][15:8]);
            logic [7:0] d0 = VEC[v][7:0];
            pulse_load(a0);
            for (int i = 0; i < n; i++) begin
                logic [3:0] o = 4'(a0[3:0] + 4'(i));
                pulse_byte(8'(d0 + 8'(i)));
                model[{a0[7:4], o}] = 8'(d0 + 8'(i));
            end
            do_commit(a0[7:4], blen, wen, badrow);
            check(blen == WRC, "R5 busy length", blen, WRC);
            check(wen == ((n > 16) ? 16 : n), "R11 write pulses per offset", wen, (n > 16) ? 16 : n);
            check(badrow == 0, "R11 writes stay in row", badrow, 0);
            compare_all("R2 R3 R4 R6 array contents after commit");
        end

        // R10: second commit with nothing new
        do_commit(4'h0, blen, wen, badrow);
        check(blen == 0, "R10 commit after completed commit", blen, 0);

        // R7: abort discards
        pulse_load(8'h50);
        pulse_byte(8'h01); pulse_byte(8'h02); pulse_byte(8'h03);
        pulse_abort();
        do_commit(4'h5, blen, wen, badrow);
        check(blen == 0, "R7 commit after abort busy", blen, 0);
        check(wen == 0, "R7 commit after abort writes", wen, 0);
        compare_all("R7 array unchanged after abort");

        // R8: commit right after load with no bytes
        pulse_load(8'h90);
        do_commit(4'h9, blen, wen, badrow);
        check(blen == 0, "R8 empty commit busy", blen, 0);

        // R9: strobes during busy are dropped
        pulse_load(8'h42);
        pulse_byte(8'h5A);
        model[8'h42] = 8'h5A;
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
        check(busy == 1'b1, "R9 busy entered", busy, 1);
        @(negedge clk); addr_load = 1'b1; addr_in = 8'h60;
        @(negedge clk); addr_load = 1'b0; byte_stb = 1'b1; byte_data = 8'h33;
        @(negedge clk); byte_data = 8'h34;
        @(negedge clk); byte_stb = 1'b0; abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        while (busy) @(negedge clk);
        do_commit(4'h6, blen, wen, badrow);
        check(blen == 0, "R9 no pending bytes from busy window", blen, 0);
        compare_all("R9 array after strobes during busy");

        // R12: abort beats commit in the same cycle; load beats byte
        pulse_load(8'hA0);
        pulse_byte(8'hEE);
        @(negedge clk); abort = 1'b1; commit_req = 1'b1;
        @(negedge clk); abort = 1'b0; commit_req = 1'b0;
        check(busy == 1'b0, "R12 abort wins over commit", busy, 0);
        @(negedge clk); addr_load = 1'b1; addr_in = 8'hB3; byte_stb = 1'b1; byte_data = 8'h99;
        @(negedge clk); addr_load = 1'b0; byte_stb = 1'b0;
        pulse_byte(8'h66);
        model[8'hB3] = 8'h66;
        do_commit(4'hB, blen, wen, badrow);
        check(wen == 1, "R12 load wins over byte", wen, 1);
        compare_all("R12 array after priority cases");

        check(stray_we == 0, "R11 arr_we outside busy", stray_we, 0);
        finish_report();
    end

endmodule